// File: doc/BRIEF.md
# Streaming Address/Data Register Window

This block lets a sequencer reach a large register space through just two kinds of register: address registers and a data register. Writing an address register stores the value and decides where later data writes land. There are two targets. Small values select the ordinary register file. Large values select a pipe-register space, in which the top byte names the pipe register. Each data write is forwarded to the current target, and the stored address then steps forward according to its encoding. Firmware can therefore stream a burst of values after a single address write.

Two address registers exist, a normal one and a user one. The one written most recently is active. A few pipe indices have side effects. Two of them load the low and high halves of a 64-bit memory pointer. A third turns each data value into a memory dword write at that pointer, and the pointer then moves on by 4 bytes. Indices marked as void take no data: selecting one of them with an address write fires a zero write to it at once. The register file, the pipe registers and memory sit outside the block, and each appears only as a one-cycle write strobe with its address and data.

Top module: `regwin_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, every write strobe and the error flag are low, both address registers read 0, the normal register is active and the memory pointer is 0.
- R2: An address write stores `addr_wdata` in the normal register when `addr_user`=0, or in the user register when `addr_user`=1, and makes that register active. `user_active` shows the choice on the next cycle.
- R3: When the active address is at most 0x0000FFFF, a data write produces `reg_we` on the next cycle, with `reg_addr` equal to the low 16 address bits and `reg_wdata` equal to the data. The active address then increases by 1, so 0xFFFF becomes 0x00010000.
- R4: When the active address is above 0x0000FFFF and valid, a data write produces `pipe_we` on the next cycle, with `pipe_idx` equal to address bits 31:24 and `pipe_wdata` equal to the data. The active address then increases by 0x01000000.
- R5: In pipe space with address bit 18 set, a data write leaves the active address unchanged.
- R6: If a pipe-space address has any of bits 23:19 or 17:0 set, a data write raises `err_stray` for one cycle. That data write produces no register, pipe or memory write and leaves the address unchanged.
- R7: An address write without a data write, whose value is a valid pipe address with index 0x30 (the void set), produces `pipe_we` to that index with data 0 on the next cycle.
- R8: Pipe writes to index 0x10 load the low 32 bits of `mem_ptr`, and pipe writes to index 0x11 load the high 32 bits.
- R9: A pipe write to index 0x12 also produces `mem_we` with `mem_addr` equal to the pointer before the write and `mem_wdata` equal to the data. The pointer then increases by 4, with carry across all 64 bits.
- R10: When an address write and a data write arrive in the same cycle, the data write uses the new address, and the stored address is the new address already advanced. Any void zero write is replaced by the data write.
- R11: Data writes never change the inactive address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_we | input | 1 | Address register write strobe |
| addr_user | input | 1 | 0 writes the normal address register, 1 the user one |
| addr_wdata | input | 32 | Address value |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 32 | Data value |
| reg_we | output | 1 | Ordinary register write strobe |
| reg_addr | output | 16 | Ordinary register index |
| reg_wdata | output | 32 | Ordinary register data |
| pipe_we | output | 1 | Pipe register write strobe |
| pipe_idx | output | 8 | Pipe register index |
| pipe_wdata | output | 32 | Pipe register data |
| mem_we | output | 1 | Memory dword write strobe |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory data |
| err_stray | output | 1 | One-cycle pulse: data write to a malformed pipe address was dropped |
| cur_addr_norm | output | 32 | Normal address register |
| cur_addr_user | output | 32 | User address register |
| user_active | output | 1 | 1 when the user address register is active |
| mem_ptr | output | 64 | Current memory pointer |

## Verification
The stimulus covers four address patterns. Ordinary bursts show that the address advances by 1 and that the low bits route to `reg_addr`. Auto-increment pipe bursts walk the index byte and load the pointer halves. Pipe addresses with bit 18 set repeat one index, which confirms the address holds and that memory dwords land at successive pointers. Malformed pipe addresses must raise the error and produce no write. Further cases are same-cycle address and data writes, the 0xFFFF boundary, the void zero write, switching between the two address registers, and a pointer that carries into its upper half. These separate the forwarding priority, register selection and pointer arithmetic from the basic routing.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned IDX_W       = 8;
  localparam int unsigned IDX_LSB     = WORD_W - IDX_W;
  localparam int unsigned HOLD_BIT    = 18;
  localparam logic [WORD_W-1:0] REG_SPACE_MAX = 32'h0000_FFFF;
  localparam logic [WORD_W-1:0] PIPE_STEP     = 32'h0100_0000;

  typedef enum logic [1:0] {
    SP_REG  = 2'd0,
    SP_PIPE = 2'd1,
    SP_BAD  = 2'd2
  } space_e;

  // Bits below the index byte that must be zero in pipe space.
  function automatic logic stray_bits(input logic [WORD_W-1:0] a);
    logic [IDX_LSB-1:0] low;
    low = a[IDX_LSB-1:0];
    low[HOLD_BIT] = 1'b0;
    return |low;
  endfunction

endpackage

// File: rtl/regwin_rst_sync.sv
module regwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/regwin_route.sv
module regwin_route
  import regwin_pkg::*;
(
  input  logic [WORD_W-1:0] addr,
  output space_e            space,
  output logic [IDX_W-1:0]  idx,
  output logic              hold,
  output logic [WORD_W-1:0] next_addr
);

  assign idx  = addr[WORD_W-1:IDX_LSB];
  assign hold = addr[HOLD_BIT];

  always_comb begin
    if (addr <= REG_SPACE_MAX)  space = SP_REG;
    else if (stray_bits(addr))  space = SP_BAD;
    else                        space = SP_PIPE;
  end

  always_comb begin
    unique case (space)
      SP_REG:  next_addr = addr + 1'b1;
      SP_PIPE: next_addr = hold ? addr : addr + PIPE_STEP;
      default: next_addr = addr;
    endcase
  end

endmodule

// File: rtl/regwin_addr_bank.sv
module regwin_addr_bank
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic              addr_user,
  input  logic [WORD_W-1:0] addr_wdata,
  input  logic              adv_en,
  input  logic [WORD_W-1:0] adv_value,
  output logic [WORD_W-1:0] cur_addr,
  output logic [WORD_W-1:0] norm_q,
  output logic [WORD_W-1:0] user_q,
  output logic              sel_user_q
);

  logic              sel_d;
  logic [WORD_W-1:0] base_norm, base_user;
  logic [WORD_W-1:0] norm_d, user_d;
  logic              norm_en, user_en;

  // Address writes land first, so a same-cycle data write sees them.
  always_comb begin
    sel_d     = addr_we ? addr_user : sel_user_q;
    base_norm = (addr_we && !addr_user) ? addr_wdata : norm_q;
    base_user = (addr_we &&  addr_user) ? addr_wdata : user_q;
    cur_addr  = sel_d ? base_user : base_norm;
    norm_d    = (adv_en && !sel_d) ? adv_value : base_norm;
    user_d    = (adv_en &&  sel_d) ? adv_value : base_user;
    norm_en   = (addr_we && !addr_user) || (adv_en && !sel_d);
    user_en   = (addr_we &&  addr_user) || (adv_en &&  sel_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q     <= '0;
      user_q     <= '0;
      sel_user_q <= 1'b0;
    end else begin
      if (norm_en) norm_q <= norm_d;
      if (user_en) user_q <= user_d;
      if (addr_we) sel_user_q <= sel_d;
    end
  end

  // R11: a data write alone never moves the register it does not target
  p_inactive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !addr_we && !sel_user_q) |=> $stable(user_q));

endmodule

// File: rtl/regwin_pipe_ptr.sv
module regwin_pipe_ptr
  import regwin_pkg::*;
#(
  parameter int unsigned     PTR_W    = 64,
  parameter logic [IDX_W-1:0] LO_IDX   = 8'h10,
  parameter logic [IDX_W-1:0] HI_IDX   = 8'h11,
  parameter logic [IDX_W-1:0] DATA_IDX = 8'h12,
  parameter int unsigned     STEP     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [PTR_W-1:0]  ptr_q
);

  localparam int unsigned HI_W = PTR_W - WORD_W;

  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;
  logic             mem_d;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    mem_d  = 1'b0;
    if (wr_en) begin
      if (wr_idx == LO_IDX) begin
        ptr_d[WORD_W-1:0] = wr_data;
        ptr_en = 1'b1;
      end else if (wr_idx == HI_IDX) begin
        ptr_d[PTR_W-1:WORD_W] = wr_data[HI_W-1:0];
        ptr_en = 1'b1;
      end else if (wr_idx == DATA_IDX) begin
        ptr_d  = ptr_q + PTR_W'(STEP);
        ptr_en = 1'b1;
        mem_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= mem_d;
      if (ptr_en) ptr_q <= ptr_d;
      if (mem_d) begin
        mem_addr  <= ptr_q;
        mem_wdata <= wr_data;
      end
    end
  end

  // R9: pointer has moved one dword past the address just written
  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ptr_q == mem_addr + PTR_W'(STEP)));

endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
  import regwin_pkg::*;
#(
  parameter int unsigned      REG_AW   = 16,
  parameter int unsigned      PTR_W    = 64,
  parameter logic [IDX_W-1:0] PTR_LO   = 8'h10,
  parameter logic [IDX_W-1:0] PTR_HI   = 8'h11,
  parameter logic [IDX_W-1:0] MEM_IDX  = 8'h12,
  parameter logic [255:0]     VOID_MAP = 256'h1 << 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic              addr_user,
  input  logic [31:0]       addr_wdata,
  input  logic              data_we,
  input  logic [31:0]       data_wdata,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_addr,
  output logic [31:0]       reg_wdata,
  output logic              pipe_we,
  output logic [7:0]        pipe_idx,
  output logic [31:0]       pipe_wdata,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              err_stray,
  output logic [31:0]       cur_addr_norm,
  output logic [31:0]       cur_addr_user,
  output logic              user_active,
  output logic [PTR_W-1:0]  mem_ptr
);

  logic              rst_sync_n;
  logic [WORD_W-1:0] cur_addr, next_addr;
  space_e            space;
  logic [IDX_W-1:0]  idx;
  logic              hold;
  logic              data_ok, void_fire;
  logic              reg_we_d, pipe_we_d, err_d;
  logic [WORD_W-1:0] pipe_wdata_d;

  regwin_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  regwin_addr_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr_we    (addr_we),
    .addr_user  (addr_user),
    .addr_wdata (addr_wdata),
    .adv_en     (data_ok),
    .adv_value  (next_addr),
    .cur_addr   (cur_addr),
    .norm_q     (cur_addr_norm),
    .user_q     (cur_addr_user),
    .sel_user_q (user_active)
  );

  regwin_route u_route (
    .addr      (cur_addr),
    .space     (space),
    .idx       (idx),
    .hold      (hold),
    .next_addr (next_addr)
  );

  always_comb begin
    data_ok      = data_we && (space != SP_BAD);
    err_d        = data_we && (space == SP_BAD);
    void_fire    = addr_we && !data_we && (space == SP_PIPE) && VOID_MAP[idx];
    reg_we_d     = data_ok && (space == SP_REG);
    pipe_we_d    = (data_ok && (space == SP_PIPE)) || void_fire;
    pipe_wdata_d = data_ok ? data_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      reg_we     <= 1'b0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      pipe_we    <= 1'b0;
      pipe_idx   <= '0;
      pipe_wdata <= '0;
      err_stray  <= 1'b0;
    end else begin
      reg_we    <= reg_we_d;
      pipe_we   <= pipe_we_d;
      err_stray <= err_d;
      if (reg_we_d) begin
        reg_addr  <= cur_addr[REG_AW-1:0];
        reg_wdata <= data_wdata;
      end
      if (pipe_we_d) begin
        pipe_idx   <= idx;
        pipe_wdata <= pipe_wdata_d;
      end
    end
  end

  regwin_pipe_ptr #(
    .PTR_W    (PTR_W),
    .LO_IDX   (PTR_LO),
    .HI_IDX   (PTR_HI),
    .DATA_IDX (MEM_IDX),
    .STEP     (4)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (pipe_we_d),
    .wr_idx    (idx),
    .wr_data   (pipe_wdata_d),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .ptr_q     (mem_ptr)
  );

  // R6: a dropped write leaves every write port quiet
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_stray |-> !(reg_we || pipe_we || mem_we));

  // R3/R4: ordinary and pipe writes never coincide
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({reg_we, pipe_we, err_stray}));

  // R9: memory writes only come from the memory pipe index
  p_mem_idx_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we |-> (pipe_we && pipe_idx == MEM_IDX && mem_wdata == pipe_wdata));

  // R2: last written address register becomes active
  p_sel_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    addr_we |=> (user_active == $past(addr_user)));

  // R5: hold bit keeps the active address in place
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (data_we && !addr_we && space == SP_PIPE && hold) |=>
      ((user_active ? cur_addr_user : cur_addr_norm) == $past(cur_addr)));

endmodule

// File: tb/regwin_decoder_bench.sv
`timescale 1ns/1ps
module regwin_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_we, addr_user, data_we;
  logic [31:0] addr_wdata, data_wdata;
  logic        reg_we, pipe_we, mem_we, err_stray, user_active;
  logic [15:0] reg_addr;
  logic [7:0]  pipe_idx;
  logic [31:0] reg_wdata, pipe_wdata, mem_wdata, cur_addr_norm, cur_addr_user;
  logic [63:0] mem_addr, mem_ptr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  regwin_decoder u_regwin_decoder (
    .clk(clk), .rst_n(rst_n),
    .addr_we(addr_we), .addr_user(addr_user), .addr_wdata(addr_wdata),
    .data_we(data_we), .data_wdata(data_wdata),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pipe_we(pipe_we), .pipe_idx(pipe_idx), .pipe_wdata(pipe_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .err_stray(err_stray), .cur_addr_norm(cur_addr_norm),
    .cur_addr_user(cur_addr_user), .user_active(user_active),
    .mem_ptr(mem_ptr)
  );

  // kind: 0 no write, 1 register write, 2 pipe write, 3 error
  typedef struct packed {
    logic        aw;
    logic        au;
    logic [31:0] ad;
    logic        dw;
    logic [31:0] dd;
    logic [1:0]  kind;
    logic [15:0] tgt;
    logic [31:0] wd;
    logic        mw;
    logic [31:0] ma;
    logic [31:0] act;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,32'h0000_0100,1'b0,32'h0,  2'd0,16'h0,   32'h0,  1'b0,32'h0,     32'h0000_0100}, // R2
    '{1'b0,1'b0,32'h0,        1'b1,32'hA1, 2'd1,16'h100, 32'hA1, 1'b0,32'h0,     32'h0000_0101}, // R3
    '{1'b0,1'b0,32'h0,        1'b1,32'hA2, 2'd1,16'h101, 32'hA2, 1'b0,32'h0,     32'h0000_0102}, // R3
    '{1'b1,1'b1,32'h1000_0000,1'b0,32'h0,  2'd0,16'h0,   32'h0,  1'b0,32'h0,     32'h1000_0000}, // R2
    '{1'b0,1'b0,32'h0,        1'b1,32'h1000,2'd2,16'h10, 32'h1000,1'b0,32'h0,    32'h1100_0000}, // R4 R8
    '{1'b0,1'b0,32'h0,        1'b1,32'h2,  2'd2,16'h11,  32'h2,  1'b0,32'h0,     32'h1200_0000}, // R4 R8
    '{1'b1,1'b1,32'h1204_0000,1'b0,32'h0,  2'd0,16'h0,   32'h0,  1'b0,32'h0,     32'h1204_0000}, // R5
    '{1'b0,1'b0,32'h0,        1'b1,32'hD0, 2'd2,16'h12,  32'hD0, 1'b1,32'h1000,  32'h1204_0000}, // R5 R9
    '{1'b0,1'b0,32'h0,        1'b1,32'hD1, 2'd2,16'h12,  32'hD1, 1'b1,32'h1004,  32'h1204_0000}, // R5 R9
    '{1'b1,1'b0,32'h0502_0000,1'b0,32'h0,  2'd0,16'h0,   32'h0,  1'b0,32'h0,     32'h0502_0000}, // R6
    '{1'b0,1'b0,32'h0,        1'b1,32'hEE, 2'd3,16'h0,   32'h0,  1'b0,32'h0,     32'h0502_0000}, // R6
    '{1'b1,1'b0,32'h3000_0000,1'b0,32'h0,  2'd2,16'h30,  32'h0,  1'b0,32'h0,     32'h3000_0000}, // R7
    '{1'b1,1'b0,32'h0000_0200,1'b1,32'hB0, 2'd1,16'h200, 32'hB0, 1'b0,32'h0,     32'h0000_0201}, // R10
    '{1'b1,1'b0,32'h3000_0000,1'b1,32'h77, 2'd2,16'h30,  32'h77, 1'b0,32'h0,     32'h3100_0000}, // R10
    '{1'b1,1'b1,32'h0000_FFFF,1'b1,32'h55, 2'd1,16'hFFFF,32'h55, 1'b0,32'h0,     32'h0001_0000}  // R3
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic idle();
    addr_we = 0; addr_user = 0; addr_wdata = '0;
    data_we = 0; data_wdata = '0;
  endtask

  // Drive at a falling edge, sample after the next rising edge.
  task automatic step(input logic aw, input logic au, input logic [31:0] ad,
                      input logic dw, input logic [31:0] dd);
    addr_we = aw; addr_user = au; addr_wdata = ad;
    data_we = dw; data_wdata = dd;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 0;
    @(negedge clk);
    chk("R1 strobes in reset", {reg_we, pipe_we, mem_we, err_stray}, 4'b0);
    do_reset();
    chk("R1 strobes", {reg_we, pipe_we, mem_we, err_stray}, 4'b0);
    chk("R1 norm", cur_addr_norm, 0);
    chk("R1 user", cur_addr_user, 0);
    chk("R1 sel", user_active, 0);
    chk("R1 ptr", mem_ptr, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VECS[i];
      t = $sformatf("vec%0d", i);
      step(v.aw, v.au, v.ad, v.dw, v.dd);
      chk({t, " R3 reg_we"},   reg_we,    v.kind == 2'd1);
      chk({t, " R4 pipe_we"},  pipe_we,   v.kind == 2'd2);
      chk({t, " R6 err"},      err_stray, v.kind == 2'd3);
      chk({t, " R9 mem_we"},   mem_we,    v.mw);
      if (v.kind == 2'd1) begin
        chk({t, " R3 reg_addr"},  reg_addr,  v.tgt);
        chk({t, " R3 reg_wdata"}, reg_wdata, v.wd);
      end
      if (v.kind == 2'd2) begin
        chk({t, " R4 pipe_idx"},   pipe_idx,   v.tgt[7:0]);
        chk({t, " R4 pipe_wdata"}, pipe_wdata, v.wd);
      end
      if (v.mw) begin
        chk({t, " R9 mem_addr"},  mem_addr,  {32'h2, v.ma});
        chk({t, " R9 mem_wdata"}, mem_wdata, v.wd);
      end
      if (v.aw) chk({t, " R2 sel"}, user_active, v.au);
      chk({t, " R2 active addr"}, user_active ? cur_addr_user : cur_addr_norm, v.act);
    end

    // R8 R9: pointer after two dword writes
    chk("R9 ptr after burst", mem_ptr, 64'h2_0000_1008);

    // R11: data writes through user register leave normal one alone
    step(1, 0, 32'h0000_0300, 0, 0);
    step(1, 1, 32'h0000_0400, 0, 0);
    step(0, 0, 0, 1, 32'h1);
    step(0, 0, 0, 1, 32'h2);
    chk("R11 normal untouched", cur_addr_norm, 32'h0000_0300);
    chk("R11 user advanced", cur_addr_user, 32'h0000_0402);

    // R9: pointer carry into the upper half
    step(1, 0, 32'h1000_0000, 1, 32'hFFFF_FFFC);
    step(0, 0, 0, 1, 32'h0);
    step(0, 0, 0, 1, 32'h99);
    chk("R9 carry mem_we", mem_we, 1);
    chk("R9 carry mem_addr", mem_addr, 64'h0000_0000_FFFF_FFFC);
    chk("R9 carry ptr", mem_ptr, 64'h1_0000_0000);

    // R6: stray bit 23 on a pipe address, address must stay
    step(1, 0, 32'h1280_0000, 0, 0);
    step(0, 0, 0, 1, 32'h5);
    chk("R6 err bit23", err_stray, 1);
    chk("R6 no mem", mem_we, 0);
    chk("R6 addr held", cur_addr_norm, 32'h1280_0000);
    @(negedge clk);
    chk("R6 err pulse ends", err_stray, 0);

    // R1: reset in mid-run clears state
    do_reset();
    chk("R1 rerun norm", cur_addr_norm, 0);
    chk("R1 rerun ptr", mem_ptr, 0);
    chk("R1 rerun sel", user_active, 0);

    finish_run();
  end

endmodule